// File: doc/BRIEF.md
# CAN Bit Timing and Arbitration Engine

This block handles one CAN node's bit level. It splits each nominal bit into time quanta. A quantum is one cycle of `tq_en`, a clock enable derived from a fast clock. The block drives the transceiver transmit pin, samples the receive pin once per bit at a programmable quantum, and reports the sampled level with a one-cycle valid pulse. The dominant bus level is logic 0, which is `txd` low. The recessive level is logic 1 and is what the bus shows when no node drives it. The bus therefore behaves as a wired-AND of all transmitters.

A transmission starts with a `start` pulse. The block then takes one bit from a valid/ready interface at each bit boundary and drives that bit for the whole of the next bit. It keeps doing this until the source stops offering bits at a boundary. While sending a 1, a dominant level at the sample point means another node has won arbitration. The block then releases the bus at once and raises `arb_lost`, which stays high until the next start. A 0 that reads back as a 1 is reported as a single-cycle bit error.

Falling edges on the receive line move the bit boundary to follow clock drift. An edge seen in quanta 1 to `cfg_sp`-1 makes the current bit one quantum longer and moves the sample point one quantum later. An edge seen at or after the sample quantum makes the bit one quantum shorter. An edge in quantum 0 changes nothing. At most one edge per bit is used.

Top module: `canbit_engine`

The engine is controlled by a state machine with four states:
- `ST_IDLE`: not transmitting; `txd` is held recessive.
- `ST_ARM`: waiting for a bit boundary after a start.
- `ST_SEND`: driving bits.
- `ST_LOST`: released after lost arbitration.

Its transitions are:
- IDLE to ARM on `start`.
- LOST to ARM on `start`.
- ARM to SEND at a boundary where a bit is offered.
- ARM to IDLE at a boundary where no bit is offered.
- SEND to SEND at a boundary where a bit is offered.
- SEND to IDLE at a boundary where no bit is offered.
- SEND to LOST on a recessive/dominant conflict at the sample point.

`start` is ignored in ARM and SEND.

## Requirements
- R1: While reset is asserted, `txd` is 1 and `tx_ready`, `rx_valid`, `arb_lost` and `bit_err` are 0.
- R2: Without a resynchronisation, consecutive `rx_valid` pulses are exactly `cfg_nbt` quanta apart, for `cfg_nbt` from 9 to 20. The quantum counter advances only in cycles where `tq_en` is 1.
- R3: The sample point is the quantum tick that completes `cfg_sp` quanta of the bit, with `cfg_sp` between 2 and `cfg_nbt`-3. At that tick `rxd` is captured into `rx_bit`, and `rx_valid` is high for exactly the following cycle. With a quantum every clock, that is `cfg_sp` cycles after the first cycle of the bit.
- R4: In ST_IDLE, `txd` is 1 and `rxd` is only observed.
- R5: `tx_ready` is high only in the last quantum tick of a bit, and only in ST_ARM or ST_SEND. A bit accepted there (`tx_valid` and `tx_ready` both 1) is driven on `txd` for the whole next bit, where 0 is dominant (low).
- R6: In ST_SEND, if `txd` is 1 and `rxd` is 0 at the sample point, `arb_lost` rises together with `rx_valid` and `txd` becomes 1 in that same cycle.
- R7: After lost arbitration, `txd` stays 1, `tx_ready` stays 0 and `arb_lost` stays 1 until a `start` pulse, which clears `arb_lost`.
- R8: In ST_SEND, a transmitted 0 that reads back 0 raises neither flag, whatever the other node sends.
- R9: In ST_SEND, if `txd` is 0 and `rxd` is 1 at the sample point, `bit_err` pulses for one cycle together with `rx_valid`, and `arb_lost` stays 0.
- R10: A falling edge on `rxd` first seen at the end of quantum k, with 1 ≤ k < `cfg_sp`, lengthens the bit to `cfg_nbt`+1 quanta and delays its sample point by one quantum.
- R11: A falling edge first seen at the end of quantum k, with k ≥ `cfg_sp`, shortens the bit to `cfg_nbt`-1 quanta.
- R12: A falling edge in quantum 0 and any rising edge change no bit length. Only the first falling edge in a bit is used; later edges in the same bit are ignored.
- R13: If no bit is offered at a boundary in ST_SEND, the transmission ends and `txd` is 1 from the next bit on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tq_en | input | 1 | One-cycle enable per time quantum |
| cfg_nbt | input | TQW | Quanta per nominal bit (9..20) |
| cfg_sp | input | TQW | Quanta before the sample point |
| start | input | 1 | Begins a transmission from idle or after lost arbitration |
| tx_valid | input | 1 | A transmit bit is offered |
| tx_bit | input | 1 | Transmit bit value, 0 = dominant |
| tx_ready | output | 1 | Bit boundary where an offered bit is taken |
| rx_valid | output | 1 | One-cycle pulse after the sample point |
| rx_bit | output | 1 | Bus level sampled at the sample point |
| arb_lost | output | 1 | Arbitration lost, held until the next start |
| bit_err | output | 1 | Transmitted 0 read back as 1 |
| rxd | input | 1 | Receive pin from the transceiver |
| txd | output | 1 | Transmit pin to the transceiver, low = dominant |

## Verification
The assertions take the following for granted:
- `rxd` is already synchronous to `clk`.
- `cfg_nbt` and `cfg_sp` stay inside their stated ranges.
- The configuration is changed only while the engine is idle.

The stimulus changes both configuration inputs only in ST_IDLE, and only between two full bit periods. Bus edges are produced only from inactive clock edges, at quanta counted from an observed `rx_valid` pulse. The bus is modelled as the AND of `txd` and a second node, plus an optional stuck-recessive term. This keeps the readback coherent with what the engine drives.

// File: rtl/canbit_pkg.sv
package canbit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_SEND,
        ST_LOST
    } eng_state_t;

endpackage

// File: rtl/canbit_tq_timer.sv
module canbit_tq_timer #(
    parameter int TQW = 5,
    localparam int CW = TQW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tq_en,
    input  logic [TQW-1:0] cfg_nbt,
    input  logic [TQW-1:0] cfg_sp,
    input  logic           len_eff,
    input  logic           shr_eff,
    output logic [CW-1:0]  tq_cnt,
    output logic           bit_end,
    output logic           samp_tick
);

    logic [CW-1:0] end_idx;
    logic [CW-1:0] samp_idx;

    always_comb begin
        end_idx  = CW'(cfg_nbt) - CW'(1) + CW'(len_eff) - CW'(shr_eff);
        samp_idx = CW'(cfg_sp) - CW'(1) + CW'(len_eff);
    end

    assign bit_end   = tq_en && (tq_cnt >= end_idx);
    assign samp_tick = tq_en && (tq_cnt == samp_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tq_cnt <= '0;
        end else if (tq_en) begin
            tq_cnt <= bit_end ? '0 : tq_cnt + CW'(1);
        end
    end

    // R2
    tq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tq_en |=> $stable(tq_cnt));

endmodule

// File: rtl/canbit_resync.sv
module canbit_resync #(
    parameter int TQW = 5,
    localparam int CW = TQW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tq_en,
    input  logic           rxd,
    input  logic [CW-1:0]  tq_cnt,
    input  logic [TQW-1:0] cfg_sp,
    input  logic           bit_end,
    output logic           len_eff,
    output logic           shr_eff
);

    logic prev_q;
    logic used_q;
    logic len_q;
    logic shr_q;
    logic fall;
    logic late_now;
    logic early_now;

    always_comb begin
        fall      = tq_en && prev_q && !rxd && !used_q;
        late_now  = fall && (tq_cnt != '0) && (tq_cnt < CW'(cfg_sp));
        early_now = fall && (tq_cnt >= CW'(cfg_sp));
        len_eff   = len_q || late_now;
        shr_eff   = shr_q || early_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            used_q <= 1'b0;
            len_q  <= 1'b0;
            shr_q  <= 1'b0;
        end else if (tq_en) begin
            prev_q <= rxd;
            if (bit_end) begin
                used_q <= 1'b0;
                len_q  <= 1'b0;
                shr_q  <= 1'b0;
            end else if (fall) begin
                used_q <= 1'b1;
                len_q  <= late_now;
                shr_q  <= early_now;
            end
        end
    end

    // R12
    one_corr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_en && !bit_end && used_q) |=> $stable({len_q, shr_q}));

    // R12
    rise_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_en && !prev_q && !used_q && !bit_end) |=> !(len_q || shr_q));

endmodule

// File: rtl/canbit_engine.sv
module canbit_engine
    import canbit_pkg::*;
#(
    parameter int TQW = 5,
    localparam int CW = TQW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tq_en,
    input  logic [TQW-1:0] cfg_nbt,
    input  logic [TQW-1:0] cfg_sp,
    input  logic           start,
    input  logic           tx_valid,
    input  logic           tx_bit,
    output logic           tx_ready,
    output logic           rx_valid,
    output logic           rx_bit,
    output logic           arb_lost,
    output logic           bit_err,
    input  logic           rxd,
    output logic           txd
);

    eng_state_t    state_q;
    eng_state_t    state_d;
    logic [CW-1:0] tq_cnt;
    logic          bit_end;
    logic          samp_tick;
    logic          len_eff;
    logic          shr_eff;
    logic          start_ok;
    logic          take;
    logic          conflict_lost;
    logic          conflict_err;

    canbit_tq_timer #(.TQW(TQW)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tq_en     (tq_en),
        .cfg_nbt   (cfg_nbt),
        .cfg_sp    (cfg_sp),
        .len_eff   (len_eff),
        .shr_eff   (shr_eff),
        .tq_cnt    (tq_cnt),
        .bit_end   (bit_end),
        .samp_tick (samp_tick)
    );

    canbit_resync #(.TQW(TQW)) resync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tq_en   (tq_en),
        .rxd     (rxd),
        .tq_cnt  (tq_cnt),
        .cfg_sp  (cfg_sp),
        .bit_end (bit_end),
        .len_eff (len_eff),
        .shr_eff (shr_eff)
    );

    always_comb begin
        tx_ready      = ((state_q == ST_ARM) || (state_q == ST_SEND)) && bit_end;
        take          = tx_ready && tx_valid;
        start_ok      = start && ((state_q == ST_IDLE) || (state_q == ST_LOST));
        conflict_lost = (state_q == ST_SEND) && samp_tick && txd && !rxd;
        conflict_err  = (state_q == ST_SEND) && samp_tick && !txd && rxd;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_d = ST_ARM;
            ST_LOST: if (start_ok) state_d = ST_ARM;
            ST_ARM:  if (tx_ready) state_d = tx_valid ? ST_SEND : ST_IDLE;
            ST_SEND: begin
                if (conflict_lost)  state_d = ST_LOST;
                else if (tx_ready)  state_d = tx_valid ? ST_SEND : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd      <= 1'b1;
            rx_valid <= 1'b0;
            rx_bit   <= 1'b1;
            arb_lost <= 1'b0;
            bit_err  <= 1'b0;
        end else begin
            rx_valid <= samp_tick;
            if (samp_tick) rx_bit <= rxd;
            bit_err <= conflict_err;
            if (start_ok)           arb_lost <= 1'b0;
            else if (conflict_lost) arb_lost <= 1'b1;
            if (conflict_lost)  txd <= 1'b1;
            else if (take)      txd <= tx_bit;
            else if (tx_ready)  txd <= 1'b1;
        end
    end

    // R4
    idle_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> txd);

    // R7
    lost_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOST) |-> (txd && !tx_ready && arb_lost));

    // R6
    backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && samp_tick && txd && !rxd) |=> (arb_lost && txd));

    // R5
    txd_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_end && !(state_q == ST_SEND && samp_tick)) |=> $stable(txd));

    // R3
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9
    berr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> (!arb_lost && rx_valid));

endmodule

// File: tb/canbit_engine_tb_top.sv
`timescale 1ns/1ps
module canbit_engine_tb_top;

    localparam int TQW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tq_en = 1'b1;
    logic [TQW-1:0] cfg_nbt = 5'd10;
    logic [TQW-1:0] cfg_sp = 5'd7;
    logic           start = 1'b0;
    logic           tx_valid = 1'b0;
    logic           tx_bit = 1'b1;
    logic           opp = 1'b1;
    logic           stuck = 1'b0;
    logic           tx_ready, rx_valid, rx_bit, arb_lost, bit_err, txd;
    logic           rxd;

    assign rxd = stuck | (txd & opp);

    always #10 clk = ~clk;

    canbit_engine #(.TQW(TQW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .cfg_nbt(cfg_nbt), .cfg_sp(cfg_sp),
        .start(start), .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .arb_lost(arb_lost), .bit_err(bit_err),
        .rxd(rxd), .txd(txd)
    );

    int errs = 0;
    int checks = 0;
    int rdy_cnt = 0;
    int rv_cnt = 0;
    bit finished = 1'b0;

    // {tx bit, other node bit, bus stuck recessive}
    localparam logic [2:0] VEC [6] = '{3'b110, 3'b010, 3'b000, 3'b100, 3'b001, 3'b101};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rv(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rx_valid);
    endtask

    task automatic send_one(input logic b, input logic o, input logic s, output int n);
        @(negedge clk);
        start = 1'b1; tx_valid = 1'b1; tx_bit = b;
        @(negedge clk);
        start = 1'b0;
        while (!tx_ready) @(negedge clk);
        @(posedge clk);
        #1;
        opp = o; stuck = s; tx_valid = 1'b0;
        wait_rv(n);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (tx_ready) rdy_cnt++;
            if (rx_valid) rv_cnt++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int r;
        logic exp_rx, exp_lost, exp_berr;
        logic [2:0] bits;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1 txd", int'(txd), 1);
        chk(!tx_ready && !rx_valid, "R1 ready/valid", int'({tx_ready, rx_valid}), 0);
        chk(!arb_lost && !bit_err, "R1 flags", int'({arb_lost, bit_err}), 0);
        rst_n = 1'b1;

        // R2 nominal bit lengths
        wait_rv(n); wait_rv(n); wait_rv(n);
        chk(n == 10, "R2 period N=10", n, 10);
        chk(txd == 1'b1, "R4 idle txd", int'(txd), 1);
        cfg_nbt = 5'd9; cfg_sp = 5'd6;
        wait_rv(n); wait_rv(n); wait_rv(n);
        chk(n == 9, "R2 period N=9", n, 9);
        cfg_nbt = 5'd20; cfg_sp = 5'd13;
        wait_rv(n); wait_rv(n); wait_rv(n);
        chk(n == 20, "R2 period N=20", n, 20);
        cfg_nbt = 5'd10; cfg_sp = 5'd7;
        wait_rv(n); wait_rv(n);

        // R2 no quantum enable, no progress
        tq_en = 1'b0;
        #1 r = rv_cnt;
        repeat (40) @(negedge clk);
        #1;
        chk(rv_cnt == r, "R2 halted", rv_cnt - r, 0);
        tq_en = 1'b1;
        wait_rv(n); wait_rv(n);

        // R12 edge in quantum 0
        wait_rv(n);
        repeat (3) @(negedge clk);
        opp = 1'b0;
        wait_rv(n);
        chk(n + 3 == 10, "R12 in-sync edge", n + 3, 10);
        opp = 1'b1;
        wait_rv(n); wait_rv(n);

        // R10 late edge at quantum 3
        wait_rv(n);
        repeat (6) @(negedge clk);
        opp = 1'b0;
        wait_rv(n);
        chk(n + 6 == 11, "R10 lengthened", n + 6, 11);
        chk(rx_bit == 1'b0, "R3 rx level", int'(rx_bit), 0);
        opp = 1'b1;
        wait_rv(n);
        chk(n == 10, "R10 following bit", n, 10);
        wait_rv(n);

        // R11 early edge at quantum 8
        wait_rv(n);
        repeat (1) @(negedge clk);
        opp = 1'b0;
        wait_rv(n);
        chk(n + 1 == 9, "R11 shortened", n + 1, 9);
        opp = 1'b1;
        wait_rv(n);
        chk(n == 10, "R11 following bit", n, 10);
        wait_rv(n);

        // R12 second edge in the same bit ignored
        wait_rv(n);
        repeat (5) @(negedge clk);
        opp = 1'b0;
        repeat (3) @(negedge clk);
        opp = 1'b1;
        wait_rv(n);
        chk(n + 8 == 11, "R12 first edge used", n + 8, 11);
        repeat (1) @(negedge clk);
        opp = 1'b0;
        wait_rv(n);
        chk(n + 1 == 10, "R12 second edge ignored", n + 1, 10);
        opp = 1'b1;
        wait_rv(n); wait_rv(n);

        // R6 R8 R9 table of single-bit transmissions
        for (int i = 0; i < 6; i++) begin
            send_one(VEC[i][2], VEC[i][1], VEC[i][0], n);
            exp_rx   = VEC[i][0] | (VEC[i][2] & VEC[i][1]);
            exp_lost = VEC[i][2] & ~exp_rx;
            exp_berr = ~VEC[i][2] & exp_rx;
            chk(n == 8, "R3 sample point", n, 8);
            chk(rx_bit == exp_rx, "R3 rx_bit", int'(rx_bit), int'(exp_rx));
            chk(arb_lost == exp_lost, "R6 R8 arb_lost", int'(arb_lost), int'(exp_lost));
            chk(bit_err == exp_berr, "R9 bit_err", int'(bit_err), int'(exp_berr));
            chk(txd == (exp_lost | VEC[i][2]), "R6 R8 txd", int'(txd), int'(exp_lost | VEC[i][2]));
            repeat (12) @(negedge clk);
            chk(txd == 1'b1, "R13 released", int'(txd), 1);
            opp = 1'b1; stuck = 1'b0;
            repeat (12) @(negedge clk);
        end

        // R7 after lost arbitration
        send_one(1'b1, 1'b0, 1'b0, n);
        chk(arb_lost == 1'b1, "R6 lost", int'(arb_lost), 1);
        tx_valid = 1'b1; tx_bit = 1'b0;
        #1 r = rdy_cnt;
        repeat (25) @(negedge clk);
        #1;
        chk(rdy_cnt == r, "R7 no ready", rdy_cnt - r, 0);
        chk(txd == 1'b1, "R7 txd held", int'(txd), 1);
        chk(arb_lost == 1'b1, "R7 flag held", int'(arb_lost), 1);
        tx_valid = 1'b0; opp = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(arb_lost == 1'b0, "R7 cleared by start", int'(arb_lost), 0);
        repeat (25) @(negedge clk);

        // R5 three-bit frame
        bits = 3'b101;
        @(negedge clk);
        start = 1'b1; tx_valid = 1'b1; tx_bit = bits[0];
        #1 r = rdy_cnt;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            while (!tx_ready) @(negedge clk);
            @(posedge clk);
            #1;
            if (i < 2) tx_bit = bits[i+1];
            else       tx_valid = 1'b0;
            wait_rv(n);
            chk(n == 8, "R5 bit timing", n, 8);
            chk(txd == bits[i], "R5 txd", int'(txd), int'(bits[i]));
            chk(rx_bit == bits[i], "R5 readback", int'(rx_bit), int'(bits[i]));
        end
        repeat (15) @(negedge clk);
        #1;
        chk(rdy_cnt - r == 4, "R5 ready pulses", rdy_cnt - r, 4);
        chk(txd == 1'b1, "R13 frame end", int'(txd), 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule